// File: doc/BRIEF.md
# Speaker Gate and System Status Port

This block is an 8-bit control and status port that sits beside an interval timer. A bus write sets two control bits. One bit drives the gate input of the timer channel that feeds the speaker. The other bit enables speaker data. The block also produces the speaker drive signal, which is the speaker channel's output level ANDed with the data enable.

A bus read returns a status byte. The byte holds the two control bits as they were last written, the live output level of the speaker timer channel, and a refresh indicator. The refresh indicator toggles at a fixed interval of about 15 microseconds. A free-running prescaler makes this interval from the clock. Its length is set by a clock-frequency parameter and an interval parameter.

The timer itself is outside this block. The gates of the other timer channels are held high at all times. Read data is registered: it appears in the cycle after the read strobe and holds until the next read.

Top module: `spkr_sysctl`

## Requirements
- R1: Bit 0 of a written byte is stored as the speaker channel gate and appears on `tmr_gate[2]` in the cycle after the write strobe.
- R2: Bit 1 of a written byte is stored as the speaker data enable and becomes visible one cycle after the write strobe.
- R3: Bit 0 of the read data returns the stored gate and bit 1 returns the stored data enable.
- R4: Bit 5 of the read data returns the speaker channel output level `spk_ch_out` sampled in the cycle of the read strobe.
- R5: Bit 4 of the read data is the refresh indicator. With the default parameters (100 MHz clock, 15 us interval) it toggles every 1500 clock cycles, and it is 0 after reset.
- R6: Read data bits 7:6 and 3:2 always read as zero.
- R7: `spk_out` equals `spk_ch_out` AND the stored data enable, registered one cycle.
- R8: While reset is asserted, the block clears the gate, the data enable, `spk_out`, the read data and the refresh indicator to zero.
- R9: The gates of channels 0 and 1 (`tmr_gate[1:0]`) are held high at all times, including during reset.
- R10: Bits 7:2 of a written byte are ignored and do not change the read data or any output.
- R11: When `rd_en` is low, `rd_data` holds its last value.
- R12: When a write and a read fall in the same cycle, the read returns the control bits as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe, one cycle per read |
| spk_ch_out | input | 1 | Output level of the speaker timer channel |
| tmr_gate | output | 3 | Gate inputs for the timer channels; bit 2 is the speaker channel |
| spk_out | output | 1 | Speaker drive: channel output AND data enable |
| rd_data | output | 8 | Registered status byte |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- The gate output follows a write strobe after one clock edge.
- The read data is loaded on the edge that samples the read strobe.
- `spk_out` settles one edge after either of its inputs changes.

A write that enables speaker data therefore reaches `spk_out` two edges after the strobe.

The bench drives every strobe for exactly one edge and samples outputs at the following falling edge. The refresh interval is measured by holding the read strobe high and counting the cycles between changes of bit 4.

// File: rtl/spkr_pkg.sv
package spkr_pkg;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned POS_GATE = 0;
  localparam int unsigned POS_EN   = 1;
  localparam int unsigned POS_REF  = 4;
  localparam int unsigned POS_OUT  = 5;

  typedef struct packed {
    logic en;
    logic gate;
  } spk_ctl_t;
endpackage

// File: rtl/spkr_ctrl_reg.sv
module spkr_ctrl_reg
  import spkr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output spk_ctl_t      ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_en) begin
      ctl_q.gate <= wr_data[POS_GATE];
      ctl_q.en   <= wr_data[POS_EN];
    end
  end
endmodule

// File: rtl/spkr_refresh_gen.sv
module spkr_refresh_gen #(
  parameter int unsigned CLK_MHZ    = 100,
  parameter int unsigned REFRESH_US = 15
) (
  input  logic clk,
  input  logic rst,
  output logic refresh_q
);
  localparam int unsigned HALF_CYC = CLK_MHZ * REFRESH_US;
  localparam int unsigned CW       = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST   = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      refresh_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q     <= '0;
      refresh_q <= ~refresh_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spkr_status_mux.sv
module spkr_status_mux
  import spkr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  spk_ctl_t          ctl,
  input  logic              refresh,
  input  logic              ch_out,
  output logic [STAT_W-1:0] rd_data
);
  logic [STAT_W-1:0] stat_c;

  always_comb begin
    stat_c           = '0;
    stat_c[POS_GATE] = ctl.gate;
    stat_c[POS_EN]   = ctl.en;
    stat_c[POS_REF]  = refresh;
    stat_c[POS_OUT]  = ch_out;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= stat_c;
  end
endmodule

// File: rtl/spkr_sysctl.sv
module spkr_sysctl
  import spkr_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 100,
  parameter int unsigned REFRESH_US = 15,
  parameter int unsigned NUM_CH     = 3,
  parameter int unsigned SPK_CH     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic              spk_ch_out,
  output logic [NUM_CH-1:0] tmr_gate,
  output logic              spk_out,
  output logic [7:0]        rd_data
);
  spk_ctl_t ctl_q;
  logic     refresh_q;

  spkr_ctrl_reg #(.DW(8)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ctl_q(ctl_q)
  );

  spkr_refresh_gen #(.CLK_MHZ(CLK_MHZ), .REFRESH_US(REFRESH_US)) u_ref (
    .clk(clk), .rst(rst), .refresh_q(refresh_q)
  );

  spkr_status_mux u_stat (
    .clk(clk), .rst(rst), .rd_en(rd_en), .ctl(ctl_q),
    .refresh(refresh_q), .ch_out(spk_ch_out), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) spk_out <= 1'b0;
    else     spk_out <= spk_ch_out & ctl_q.en;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_gate
    if (g == SPK_CH) begin : g_spk
      assign tmr_gate[g] = ctl_q.gate;
    end else begin : g_tied
      assign tmr_gate[g] = 1'b1;
    end
  end
endmodule

// File: rtl/spkr_sysctl_chk.sv
module spkr_sysctl_chk #(
  parameter int unsigned CLK_MHZ    = 100,
  parameter int unsigned REFRESH_US = 15,
  parameter int unsigned NUM_CH     = 3,
  parameter int unsigned SPK_CH     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              rd_en,
  input logic              spk_ch_out,
  input logic [NUM_CH-1:0] tmr_gate,
  input logic              spk_out,
  input logic [7:0]        rd_data,
  input logic              refresh_q
);
  localparam int unsigned HALF_CYC = CLK_MHZ * REFRESH_US;

  int unsigned gap_q;
  logic        ref_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= 0;
      ref_d <= 1'b0;
    end else begin
      ref_d <= refresh_q;
      gap_q <= (refresh_q != ref_d) ? 1 : gap_q + 1;
    end
  end

  a_r1_gate_follows: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> tmr_gate[SPK_CH] == $past(wr_data[0]));
  a_r4_out_level: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data[5] == $past(spk_ch_out));
  a_r5_refresh_gap: assert property (@(posedge clk) disable iff (rst)
    gap_q <= HALF_CYC);
  a_r6_unused_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:6] == 2'b00 && rd_data[3:2] == 2'b00);
  a_r7_spk_gated: assert property (@(posedge clk) disable iff (rst)
    spk_out |-> $past(spk_ch_out));
  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (spk_out == 1'b0 && rd_data == 8'h00 && tmr_gate[SPK_CH] == 1'b0));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  a_r9_tied_gates: assert property (@(posedge clk)
    $countones(tmr_gate) >= NUM_CH - 1);
endmodule

bind spkr_sysctl spkr_sysctl_chk #(
  .CLK_MHZ(CLK_MHZ), .REFRESH_US(REFRESH_US), .NUM_CH(NUM_CH), .SPK_CH(SPK_CH)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
  .spk_ch_out(spk_ch_out), .tmr_gate(tmr_gate), .spk_out(spk_out),
  .rd_data(rd_data), .refresh_q(refresh_q)
);

// File: tb/tb_spkr_sysctl.sv
module tb_spkr_sysctl;
  localparam int HALF = 1500;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic       spk_ch_out = 1'b0;
  logic [2:0] tmr_gate;
  logic       spk_out;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spkr_sysctl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .spk_ch_out(spk_ch_out), .tmr_gate(tmr_gate), .spk_out(spk_out),
    .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read();
    rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 gate", tmr_gate[2], 0);
    chk("R9 tied gates in reset", tmr_gate[1:0], 3);
    chk("R8 spk", spk_out, 0);
    chk("R8 rd_data", rd_data, 0);
    rst = 1'b0;
    do_read();
    chk("R8 status after reset", rd_data & 8'hDF, 8'h00);
  endtask

  task automatic t_gate_write();
    do_write(8'h01);
    chk("R1 gate set", tmr_gate[2], 1);
    chk("R9 tied gates", tmr_gate[1:0], 3);
    do_write(8'h00);
    chk("R1 gate clear", tmr_gate[2], 0);
  endtask

  task automatic t_readback();
    spk_ch_out = 1'b0;
    do_write(8'h02);
    do_read();
    chk("R2/R3 en only", rd_data & 8'h03, 8'h02);
    do_write(8'h03);
    do_read();
    chk("R3 both bits", rd_data & 8'h03, 8'h03);
    do_write(8'h01);
    do_read();
    chk("R3 gate only", rd_data & 8'h03, 8'h01);
  endtask

  task automatic t_out_level();
    spk_ch_out = 1'b1;
    do_read();
    chk("R4 out high", rd_data[5], 1);
    spk_ch_out = 1'b0;
    do_read();
    chk("R4 out low", rd_data[5], 0);
  endtask

  task automatic t_speaker();
    do_write(8'h00);
    spk_ch_out = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 disabled", spk_out, 0);
    do_write(8'h02);
    chk("R7 not yet", spk_out, 0);
    @(posedge clk); @(negedge clk);
    chk("R7 enabled high", spk_out, 1);
    spk_ch_out = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R7 follows low", spk_out, 0);
  endtask

  task automatic t_unused();
    spk_ch_out = 1'b1;
    do_write(8'hFC);
    do_read();
    chk("R10 high bits ignored", rd_data & 8'h03, 0);
    chk("R6 unused zero", rd_data & 8'hCC, 0);
    chk("R10 gate unaffected", tmr_gate, 3'b011);
    @(posedge clk); @(negedge clk);
    chk("R10 spk unaffected", spk_out, 0);
    spk_ch_out = 1'b0;
  endtask

  task automatic t_same_cycle();
    do_write(8'h00);
    wr_data = 8'h03; wr_en = 1'b1; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R12 old value", rd_data & 8'h03, 0);
    do_read();
    chk("R12 new value next read", rd_data & 8'h03, 3);
  endtask

  task automatic t_hold();
    logic [7:0] snap;
    do_read();
    snap = rd_data;
    do_write(8'h00);
    spk_ch_out = ~spk_ch_out;
    @(posedge clk); @(negedge clk);
    chk("R11 hold", rd_data, snap);
  endtask

  task automatic t_refresh();
    int t0, t1, n;
    logic prev;
    t0 = -1; t1 = -1;
    rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    prev = rd_data[4];
    for (int i = 0; i < 4 * HALF && t1 < 0; i++) begin
      @(posedge clk); @(negedge clk);
      if (rd_data[4] != prev) begin
        if (t0 < 0) t0 = i; else t1 = i;
        prev = rd_data[4];
      end
    end
    rd_en = 1'b0;
    n = t1 - t0;
    chk("R5 refresh interval", n, HALF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_gate_write();
    t_readback();
    t_out_level();
    t_speaker();
    t_unused();
    t_same_cycle();
    t_hold();
    t_refresh();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule